// File: doc/BRIEF.md
# Page Access Permission and Fault-Code Checker

This block decides whether a memory access may use a translated page. The page-table walk that comes before it has reduced the entry chain to one effective user bit, one writable bit, one no-execute bit and a 4-bit protection key. The walk also reports whether it already failed because an entry was absent or had reserved bits set. The checker combines those page attributes with the access type, the privilege of the requester and the active paging controls. From these it produces read, write and execute grants, or a fault flag and the 32-bit page-fault error code that a fault handler expects.

Supervisor-execute blocking, supervisor-access blocking of user pages and per-key access-disable and write-disable rights all feed one grant mask. The decision is registered. A request strobe yields a result one cycle later together with a one-cycle result-valid pulse, and the outputs hold between results.

Top module: `perm_check`

## Requirements
- R1: Results appear on the clock edge after `req_valid_i` and `rsp_valid_o` is high for exactly that cycle. Without a request the outputs hold their value. Reset clears all outputs to zero.
- R2: A user-mode access to a page whose effective user bit is clear faults with error bits 0 and 2 set, and no key bit is set.
- R3: Read is granted unless `sup_prevent_i` is set and the page is a user page.
- R4: Write needs read permission plus either the page writable bit, or a supervisor access with `ctl_wp_i` clear.
- R5: Execute is granted only when no-execute is clear and, for supervisor accesses, not when `ctl_smep_i` is set on a user page.
- R6: Key rights apply only when `ctl_pke_i`, `ctl_long_i` and the page user bit are all set and `key_rights_i` is nonzero. Key k uses bit 2k for access-disable and bit 2k+1 for write-disable.
- R7: Access-disable removes read and write. Write-disable removes write only for user accesses or when WP is set. Execute is never removed by a key. A denial caused by a key sets error bit 5.
- R8: With a fault, all grants are zero, error bit 1 equals (access is write), bit 2 equals user mode, and bits 31..6 are zero. Without a fault, the error code is zero.
- R9: Walk kind 2'b10 (reserved) faults with error bits 0 and 3 set.
- R10: Error bit 4 is set only for fetches, and only when either both `ctl_nxe_i` and `ctl_pae_i` are set or `ctl_smep_i` is set.
- R11: With `ctl_nxe_i` clear, a set no-execute bit is a reserved-bit fault (bits 0 and 3).
- R12: Walk kind 2'b01 (not present) faults with bits 0 and 3 clear, while bits 1, 2 and 4 follow their rules.
- R13: Access encoding is 2'b00 read, 2'b01 write, 2'b10 fetch, and 2'b11 behaves as read. An access faults when its required grant is missing. Walk kind 2'b00 and 2'b11 both mean no walk fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| pte_user_i | input | 1 | Effective user bit |
| pte_write_i | input | 1 | Effective writable bit |
| pte_nx_i | input | 1 | Effective no-execute bit |
| pte_key_i | input | 4 | Protection key of the entry |
| access_i | input | 2 | Access type |
| user_mode_i | input | 1 | Access from user mode |
| sup_prevent_i | input | 1 | Supervisor access with user-page access blocking active |
| ctl_wp_i | input | 1 | Supervisor write protect |
| ctl_smep_i | input | 1 | Supervisor execute blocking of user pages |
| ctl_pke_i | input | 1 | Protection keys enabled |
| ctl_nxe_i | input | 1 | No-execute enabled |
| ctl_pae_i | input | 1 | Extended paging format |
| ctl_long_i | input | 1 | Long mode active |
| key_rights_i | input | 32 | Per-key rights register |
| walk_fault_i | input | 2 | Walk fault kind |
| rsp_valid_o | output | 1 | Result valid pulse |
| grant_r_o | output | 1 | Read granted |
| grant_w_o | output | 1 | Write granted |
| grant_x_o | output | 1 | Execute granted |
| fault_o | output | 1 | Access faults |
| err_code_o | output | 32 | Page-fault error code |

## Verification
A wrong intermediate decision shows up in the single registered result, exactly one cycle after the request. It appears either as a grant bit that differs, a fault flag that differs, or a misplaced bit in the error code. Key-bit selection errors show only when the rights word is set for a neighbouring key, so vectors set rights for one key and select another. Priority mistakes between absent, reserved, user and key faults show as wrong bits 0, 3 or 5 on the same response.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    WF_NONE   = 2'b00,
    WF_ABSENT = 2'b01,
    WF_RSVD   = 2'b10,
    WF_SPARE  = 2'b11
  } walk_e;

  localparam int EC_PROT  = 0;
  localparam int EC_WR    = 1;
  localparam int EC_USER  = 2;
  localparam int EC_RSVD  = 3;
  localparam int EC_FETCH = 4;
  localparam int EC_KEY   = 5;
  localparam int EC_USED  = 6;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;
endpackage

// File: rtl/perm_grant.sv
module perm_grant
  import perm_pkg::*;
(
  input  logic pte_user_i,
  input  logic pte_write_i,
  input  logic pte_nx_i,
  input  logic user_mode_i,
  input  logic sup_prevent_i,
  input  logic wp_i,
  input  logic smep_i,
  output rwx_t base_o
);
  always_comb begin
    base_o.r = !(sup_prevent_i && pte_user_i);
    base_o.w = base_o.r && (pte_write_i || (!user_mode_i && !wp_i));
    base_o.x = !pte_nx_i && (user_mode_i || !(smep_i && pte_user_i));
  end
endmodule

// File: rtl/perm_key.sv
module perm_key
  import perm_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int RIGHTS_W = 2 << KEY_W
) (
  input  logic [KEY_W-1:0]    key_i,
  input  logic [RIGHTS_W-1:0] rights_i,
  input  logic                pke_i,
  input  logic                long_i,
  input  logic                pte_user_i,
  input  logic                user_mode_i,
  input  logic                wp_i,
  output rwx_t                mask_o
);
  logic active, acc_dis, wr_dis;

  assign active  = pke_i && long_i && pte_user_i && (|rights_i);
  assign acc_dis = rights_i[{key_i, 1'b0}];
  assign wr_dis  = rights_i[{key_i, 1'b1}];

  always_comb begin
    mask_o.r = !(active && acc_dis);
    mask_o.w = !(active && (acc_dis || (wr_dis && (user_mode_i || wp_i))));
    mask_o.x = 1'b1;
  end
endmodule

// File: rtl/perm_errcode.sv
module perm_errcode
  import perm_pkg::*;
#(
  parameter int EC_W = 32
) (
  input  logic [1:0]      walk_i,
  input  logic [1:0]      access_i,
  input  logic            nx_rsvd_i,
  input  logic            pte_user_i,
  input  logic            user_mode_i,
  input  rwx_t            base_i,
  input  rwx_t            mask_i,
  input  logic            nxe_i,
  input  logic            pae_i,
  input  logic            smep_i,
  output logic            fault_o,
  output logic [EC_W-1:0] ec_o
);
  logic absent, rsvd, is_wr, is_fetch;
  logic base_req, key_req, user_flt, key_deny, prot;

  assign absent   = (walk_i == WF_ABSENT);
  assign rsvd     = !absent && ((walk_i == WF_RSVD) || nx_rsvd_i);
  assign is_wr    = (access_i == ACC_WRITE);
  assign is_fetch = (access_i == ACC_FETCH);

  always_comb begin
    if (is_wr) begin
      base_req = base_i.w;
      key_req  = mask_i.w;
    end else if (is_fetch) begin
      base_req = base_i.x;
      key_req  = mask_i.x;
    end else begin
      base_req = base_i.r;
      key_req  = mask_i.r;
    end
  end

  assign user_flt = user_mode_i && !pte_user_i;
  assign key_deny = !user_flt && !key_req;
  assign prot     = user_flt || key_deny || !base_req;
  assign fault_o  = absent || rsvd || prot;

  always_comb begin
    ec_o = '0;
    if (fault_o) begin
      ec_o[EC_PROT]  = !absent;
      ec_o[EC_WR]    = is_wr;
      ec_o[EC_USER]  = user_mode_i;
      ec_o[EC_RSVD]  = rsvd;
      ec_o[EC_FETCH] = is_fetch && ((nxe_i && pae_i) || smep_i);
      ec_o[EC_KEY]   = !absent && !rsvd && key_deny;
    end
  end
endmodule

// File: rtl/perm_check.sv
module perm_check
  import perm_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter int EC_W  = 32,
  localparam int RIGHTS_W = 2 << KEY_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                pte_user_i,
  input  logic                pte_write_i,
  input  logic                pte_nx_i,
  input  logic [KEY_W-1:0]    pte_key_i,
  input  logic [1:0]          access_i,
  input  logic                user_mode_i,
  input  logic                sup_prevent_i,
  input  logic                ctl_wp_i,
  input  logic                ctl_smep_i,
  input  logic                ctl_pke_i,
  input  logic                ctl_nxe_i,
  input  logic                ctl_pae_i,
  input  logic                ctl_long_i,
  input  logic [RIGHTS_W-1:0] key_rights_i,
  input  logic [1:0]          walk_fault_i,
  output logic                rsp_valid_o,
  output logic                grant_r_o,
  output logic                grant_w_o,
  output logic                grant_x_o,
  output logic                fault_o,
  output logic [EC_W-1:0]     err_code_o
);
  rwx_t            base, mask, eff;
  logic            nx_rsvd, flt;
  logic [EC_W-1:0] ec;

  // no-execute bit is reserved when the feature is off
  assign nx_rsvd = pte_nx_i && !ctl_nxe_i;

  perm_grant u_grant (
    .pte_user_i    (pte_user_i),
    .pte_write_i   (pte_write_i),
    .pte_nx_i      (pte_nx_i),
    .user_mode_i   (user_mode_i),
    .sup_prevent_i (sup_prevent_i),
    .wp_i          (ctl_wp_i),
    .smep_i        (ctl_smep_i),
    .base_o        (base)
  );

  perm_key #(.KEY_W(KEY_W)) u_key (
    .key_i       (pte_key_i),
    .rights_i    (key_rights_i),
    .pke_i       (ctl_pke_i),
    .long_i      (ctl_long_i),
    .pte_user_i  (pte_user_i),
    .user_mode_i (user_mode_i),
    .wp_i        (ctl_wp_i),
    .mask_o      (mask)
  );

  perm_errcode #(.EC_W(EC_W)) u_ec (
    .walk_i      (walk_fault_i),
    .access_i    (access_i),
    .nx_rsvd_i   (nx_rsvd),
    .pte_user_i  (pte_user_i),
    .user_mode_i (user_mode_i),
    .base_i      (base),
    .mask_i      (mask),
    .nxe_i       (ctl_nxe_i),
    .pae_i       (ctl_pae_i),
    .smep_i      (ctl_smep_i),
    .fault_o     (flt),
    .ec_o        (ec)
  );

  assign eff = flt ? rwx_t'('0) : (base & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      grant_r_o   <= 1'b0;
      grant_w_o   <= 1'b0;
      grant_x_o   <= 1'b0;
      fault_o     <= 1'b0;
      err_code_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        grant_r_o  <= eff.r;
        grant_w_o  <= eff.w;
        grant_x_o  <= eff.x;
        fault_o    <= flt;
        err_code_o <= ec;
      end
    end
  end
endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva #(
  parameter int KEY_W = 4,
  parameter int EC_W  = 32,
  localparam int RIGHTS_W = 2 << KEY_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                pte_user_i,
  input logic                pte_write_i,
  input logic                pte_nx_i,
  input logic [KEY_W-1:0]    pte_key_i,
  input logic [1:0]          access_i,
  input logic                user_mode_i,
  input logic                sup_prevent_i,
  input logic                ctl_wp_i,
  input logic                ctl_smep_i,
  input logic                ctl_pke_i,
  input logic                ctl_nxe_i,
  input logic                ctl_pae_i,
  input logic                ctl_long_i,
  input logic [RIGHTS_W-1:0] key_rights_i,
  input logic [1:0]          walk_fault_i,
  input logic                rsp_valid_o,
  input logic                grant_r_o,
  input logic                grant_w_o,
  input logic                grant_x_o,
  input logic                fault_o,
  input logic [EC_W-1:0]     err_code_o
);
  assert_rsp_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(err_code_o) && $stable(fault_o) && $stable(grant_r_o));
  assert_user_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && user_mode_i && !pte_user_i |=> fault_o && err_code_o[2] && !err_code_o[5]);
  assert_fault_nogrant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o |-> !grant_r_o && !grant_w_o && !grant_x_o);
  assert_clean_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !fault_o |-> err_code_o == '0);
  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o[EC_W-1:6] == '0);
  assert_rsvd_prot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && err_code_o[3] |-> err_code_o[0] && fault_o);
  assert_fetch_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && access_i != 2'b10 |=> !err_code_o[4]);
  assert_nx_rsvd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && walk_fault_i == 2'b00 && pte_nx_i && !ctl_nxe_i |=> fault_o && err_code_o[3]);
  assert_absent_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && walk_fault_i == 2'b01 |=> fault_o && !err_code_o[0] && !err_code_o[3]);
  assert_key_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && err_code_o[5] |-> err_code_o[0] && !err_code_o[3]);
endmodule

bind perm_check perm_check_sva #(.KEY_W(KEY_W), .EC_W(EC_W)) u_sva (.*);

// File: tb/perm_check_tb.sv
module perm_check_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic u, w, nx;
    logic [3:0] key;
    logic [1:0] acc;
    logic um, sp, wp, smep, pke, nxe, pae, lng;
    logic [31:0] rights;
    logic [1:0] wf;
    logic [2:0] exp_rwx;
    logic exp_f;
    logic [5:0] exp_ec;
    logic [3:0] rq;
  } vec_t;

  // fields: u w nx key acc um sp wp smep pke nxe pae lng rights wf | rwx f ec req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b111,1'b0,6'h00,4'd3},  // R3 plain user read
    '{1'b0,1'b1,1'b0,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h05,4'd2},  // R2
    '{1'b1,1'b0,1'b0,4'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h07,4'd4},  // R4 user write ro
    '{1'b0,1'b0,1'b0,4'd0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b111,1'b0,6'h00,4'd4},  // R4 sup write wp=0
    '{1'b0,1'b0,1'b0,4'd0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h03,4'd4},  // R4 sup write wp=1
    '{1'b1,1'b1,1'b0,4'd0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h01,4'd3},  // R3 sup prevent
    '{1'b1,1'b1,1'b0,4'd0,2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h11,4'd5},  // R5 smep
    '{1'b1,1'b1,1'b1,4'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h15,4'd5},  // R5 nx fetch
    '{1'b1,1'b1,1'b1,4'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,32'h0,2'd0,3'b000,1'b1,6'h05,4'd10}, // R10 no pae
    '{1'b1,1'b1,1'b1,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h0,2'd0,3'b000,1'b1,6'h0D,4'd11}, // R11
    '{1'b1,1'b1,1'b0,4'd0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd2,3'b000,1'b1,6'h0B,4'd9},  // R9
    '{1'b1,1'b1,1'b0,4'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd1,3'b000,1'b1,6'h14,4'd12}, // R12
    '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h40,2'd0,3'b000,1'b1,6'h25,4'd7}, // R7 AD read
    '{1'b1,1'b1,1'b0,4'd3,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h80,2'd0,3'b000,1'b1,6'h27,4'd7}, // R7 WD write
    '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h80,2'd0,3'b101,1'b0,6'h00,4'd7}, // R7 WD read
    '{1'b1,1'b1,1'b0,4'd3,2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h80,2'd0,3'b111,1'b0,6'h00,4'd7}, // R7 WD sup wp=0
    '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h40,2'd0,3'b111,1'b0,6'h00,4'd6}, // R6 pke off
    '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h40,2'd0,3'b111,1'b0,6'h00,4'd6}, // R6 long off
    '{1'b1,1'b1,1'b0,4'd2,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h40,2'd0,3'b111,1'b0,6'h00,4'd6}, // R6 other key
    '{1'b1,1'b1,1'b0,4'd3,2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h40,2'd0,3'b001,1'b0,6'h00,4'd7}, // R7 AD fetch
    '{1'b0,1'b1,1'b0,4'd3,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,32'h40,2'd0,3'b111,1'b0,6'h00,4'd6}, // R6 sup page
    '{1'b1,1'b0,1'b0,4'd0,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0,2'd3,3'b101,1'b0,6'h00,4'd13}  // R13 alt codes
  };

  logic clk, rst_n, req_valid;
  logic pte_user, pte_write, pte_nx, user_mode, sup_prevent;
  logic wp, smep, pke, nxe, pae, lng;
  logic [3:0] key;
  logic [1:0] acc, wf;
  logic [31:0] rights;
  logic rsp_valid, g_r, g_w, g_x, fault;
  logic [31:0] ec;
  int checks = 0;
  int errors = 0;

  perm_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .pte_user_i(pte_user), .pte_write_i(pte_write), .pte_nx_i(pte_nx),
    .pte_key_i(key), .access_i(acc), .user_mode_i(user_mode),
    .sup_prevent_i(sup_prevent), .ctl_wp_i(wp), .ctl_smep_i(smep),
    .ctl_pke_i(pke), .ctl_nxe_i(nxe), .ctl_pae_i(pae), .ctl_long_i(lng),
    .key_rights_i(rights), .walk_fault_i(wf),
    .rsp_valid_o(rsp_valid), .grant_r_o(g_r), .grant_w_o(g_w), .grant_x_o(g_x),
    .fault_o(fault), .err_code_o(ec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_inputs(input vec_t v);
    pte_user = v.u; pte_write = v.w; pte_nx = v.nx; key = v.key; acc = v.acc;
    user_mode = v.um; sup_prevent = v.sp; wp = v.wp; smep = v.smep; pke = v.pke;
    nxe = v.nxe; pae = v.pae; lng = v.lng; rights = v.rights; wf = v.wf;
  endtask

  function automatic logic [35:0] pack_out();
    return {rsp_valid, g_r, g_w, g_x, ec};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    set_inputs(VECS[0]);
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {pack_out()[35:0]} | {35'b0, fault}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      set_inputs(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if ({rsp_valid, g_r, g_w, g_x, fault, ec} !== {1'b1, VECS[i].exp_rwx, VECS[i].exp_f, 26'b0, VECS[i].exp_ec}) begin
        errors++;
        $display("FAIL R%0d vec %0d actual v=%b rwx=%b f=%b ec=%h expected v=1 rwx=%b f=%b ec=%h",
                 VECS[i].rq, i, rsp_valid, {g_r, g_w, g_x}, fault, ec,
                 VECS[i].exp_rwx, VECS[i].exp_f, {26'b0, VECS[i].exp_ec});
      end
    end

    // R1 pulse ends and result holds while inputs change without a request
    set_inputs(VECS[1]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    set_inputs(VECS[0]);
    @(negedge clk);
    check("R1 pulse single cycle", {35'b0, rsp_valid}, 36'h0);
    check("R1 hold fault code", {3'b0, fault, ec}, {3'b0, 1'b1, 32'h5});
    check("R1 hold grants", {33'b0, g_r, g_w, g_x}, 36'h0);

    // R1 back-to-back requests
    set_inputs(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", {fault, rsp_valid, g_r, g_w, g_x, 31'b0}, {1'b0, 4'b1111, 31'b0});
    set_inputs(VECS[4]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 b2b second", {3'b0, fault, ec}, {3'b0, 1'b1, 32'h3});

    // R1 asynchronous reset clears outputs
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", {fault, pack_out()[34:0]}, 36'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule